// File: doc/BRIEF.md
# Byte-Enable Aligned Cycle Splitter

This block takes one data beat from a 32-bit little-endian request port. The beat comes with four active-low byte enables. The block turns the beat into a series of naturally aligned cycles on a downstream bus, and no cycle is wider than a programmed maximum width of 8, 16 or 32 bits. For each cycle it presents a byte address, a size code and an active-high lane mask. It holds these until the downstream side acknowledges, and then moves on to the next cycle.

A beat whose enables already form an aligned unit (all four bytes, or one aligned halfword) is cut into pieces of that unit, capped at the programmed width. Any other pattern is issued as single bytes: three contiguous bytes, bytes straddling a halfword boundary, and sparse bytes alike. Cycles go out from the lowest enabled byte upward. The requester holds the beat and the width input stable from valid until ready. Ready is a one-cycle pulse that marks completion of the whole beat.

Top module: `beat_splitter`

## Requirements
- R1: After reset, `beat_ready_o` and `cyc_req_o` are low, and they stay low until a beat is offered.
- R2: Every cycle is naturally aligned. Size code 0 is one byte at any offset. Size code 1 is two bytes at an even offset. Size code 2 is four bytes at offset 0.
- R3: No cycle exceeds the width selected by `max_width_i`. Code 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 select 32 bits.
- R4: `cyc_lanes_o` has the bits set for the bytes the cycle covers: 1, 2 or 4 consecutive bits starting at bit `cyc_addr_o[1:0]`. Bit n is byte n.
- R5: The cycles of one beat together cover every enabled byte (where `beat_be_ni` bit n is 0) exactly once, and they cover no disabled byte.
- R6: Cycles of a beat are issued in strictly ascending byte offset.
- R7: A wider cycle is used only for an aligned enable pattern. Enables 1111 give 4-byte cycles, or 2-byte cycles at 16 bits. Enables 0011 or 1100 (active high) give one 2-byte cycle. Every other pattern, including any three-byte pattern, gives single-byte cycles, whatever the width.
- R8: A beat with no enabled byte issues no cycle. `beat_ready_o` rises in the cycle after acceptance.
- R9: `beat_ready_o` rises only in the cycle after the last cycle is acknowledged, lasts one cycle, and is never high together with `cyc_req_o`.
- R10: While `cyc_req_o` is high and `cyc_ack_i` is low, the request and its address, size and lanes stay unchanged.
- R11: `cyc_addr_o[31:2]` equals the beat's word address `beat_word_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_valid_i | input | 1 | Beat offered; held until ready |
| beat_ready_o | output | 1 | One-cycle pulse: beat fully issued |
| beat_word_i | input | ADDR_W-2 | Word address of the beat |
| beat_be_ni | input | 4 | Byte enables, active low, bit n = byte n |
| max_width_i | input | 2 | Maximum cycle width: 00=8, 01=16, 1x=32 bits |
| cyc_req_o | output | 1 | Downstream cycle request |
| cyc_ack_i | input | 1 | Downstream cycle done |
| cyc_addr_o | output | ADDR_W | Byte address of the cycle |
| cyc_size_o | output | 2 | 0=byte, 1=halfword, 2=word |
| cyc_lanes_o | output | 4 | Active-high lane mask of the cycle |

## Verification
The state that matters is the remaining-lane mask and the latched chunk size. If the mask is wrong, a byte goes missing, is issued twice, or comes out of order, and this shows at the first cycle request after the corruption. A latched chunk size that is too wide shows at once as a misaligned or over-wide request. An early exit from the issue state shows as a ready pulse while expected cycles are still missing. The directed beats cover every class of enable pattern at each width, with acknowledge stalls, so each of these faults appears within a few clocks of the beat that triggers it.

// File: rtl/beat_split_pkg.sv
package beat_split_pkg;
  localparam int LANES = 4;
  localparam int OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } cyc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FIN   = 2'd2
  } split_state_e;

  function automatic logic [LANES-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_WORD: size_mask = 4'b1111;
      SZ_HALF: size_mask = 4'b0011;
      default: size_mask = 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/chunk_sizer.sv
module chunk_sizer
  import beat_split_pkg::*;
(
  input  logic [LANES-1:0] en_i,
  input  logic [1:0]       width_i,
  output logic [1:0]       size_o
);
  logic [1:0] cap;

  always_comb begin
    if (width_i[1])      cap = SZ_WORD;
    else if (width_i[0]) cap = SZ_HALF;
    else                 cap = SZ_BYTE;
  end

  // only aligned enable patterns earn a wide chunk
  always_comb begin
    case (en_i)
      4'b1111:         size_o = cap;
      4'b0011,
      4'b1100:         size_o = (cap == SZ_BYTE) ? SZ_BYTE : SZ_HALF;
      default:         size_o = SZ_BYTE;
    endcase
  end
endmodule

// File: rtl/lowest_lane.sv
module lowest_lane #(
  parameter int N     = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
  import beat_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  input  logic [ADDR_W-3:0] beat_word_i,
  input  logic [LANES-1:0]  en_i,
  input  logic [1:0]        chunk_i,
  input  logic [OFF_W-1:0]  low_i,
  input  logic              cyc_ack_i,
  output logic [LANES-1:0]  rem_o,
  output logic              beat_ready_o,
  output logic              cyc_req_o,
  output logic [ADDR_W-1:0] cyc_addr_o,
  output logic [1:0]        cyc_size_o,
  output logic [LANES-1:0]  cyc_lanes_o
);
  split_state_e            state_q;
  logic [LANES-1:0]        rem_q;
  logic [ADDR_W-3:0]       word_q;
  logic [1:0]              size_q;
  logic [LANES-1:0]        rem_next;

  assign cyc_lanes_o = size_mask(size_q) << low_i;
  assign rem_next    = rem_q & ~cyc_lanes_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      word_q  <= '0;
      size_q  <= SZ_BYTE;
    end else begin
      case (state_q)
        ST_IDLE: if (beat_valid_i) begin
          word_q  <= beat_word_i;
          size_q  <= chunk_i;
          rem_q   <= en_i;
          state_q <= (en_i == '0) ? ST_FIN : ST_ISSUE;
        end
        ST_ISSUE: if (cyc_ack_i) begin
          rem_q <= rem_next;
          if (rem_next == '0) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rem_o        = rem_q;
  assign cyc_req_o    = (state_q == ST_ISSUE);
  assign beat_ready_o = (state_q == ST_FIN);
  assign cyc_addr_o   = {word_q, low_i};
  assign cyc_size_o   = size_q;
endmodule

// File: rtl/beat_splitter.sv
module beat_splitter
  import beat_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  output logic              beat_ready_o,
  input  logic [ADDR_W-3:0] beat_word_i,
  input  logic [3:0]        beat_be_ni,
  input  logic [1:0]        max_width_i,
  output logic              cyc_req_o,
  input  logic              cyc_ack_i,
  output logic [ADDR_W-1:0] cyc_addr_o,
  output logic [1:0]        cyc_size_o,
  output logic [3:0]        cyc_lanes_o
);
  logic [LANES-1:0] en;
  logic [LANES-1:0] rem;
  logic [1:0]       chunk;
  logic [OFF_W-1:0] low;

  assign en = ~beat_be_ni;

  chunk_sizer u_sizer (
    .en_i    (en),
    .width_i (max_width_i),
    .size_o  (chunk)
  );

  lowest_lane #(.N(LANES)) u_low (
    .mask_i (rem),
    .idx_o  (low)
  );

  split_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_valid_i (beat_valid_i),
    .beat_word_i  (beat_word_i),
    .en_i         (en),
    .chunk_i      (chunk),
    .low_i        (low),
    .cyc_ack_i    (cyc_ack_i),
    .rem_o        (rem),
    .beat_ready_o (beat_ready_o),
    .cyc_req_o    (cyc_req_o),
    .cyc_addr_o   (cyc_addr_o),
    .cyc_size_o   (cyc_size_o),
    .cyc_lanes_o  (cyc_lanes_o)
  );
endmodule

// File: rtl/beat_splitter_chk.sv
module beat_splitter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              beat_ready_o,
  input logic [3:0]        beat_be_ni,
  input logic [1:0]        max_width_i,
  input logic              cyc_req_o,
  input logic              cyc_ack_i,
  input logic [ADDR_W-1:0] cyc_addr_o,
  input logic [1:0]        cyc_size_o,
  input logic [3:0]        cyc_lanes_o
);
  assert_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o |-> (cyc_size_o == 2'd0) ||
                  (cyc_size_o == 2'd1 && !cyc_addr_o[0]) ||
                  (cyc_size_o == 2'd2 && cyc_addr_o[1:0] == 2'b00));

  assert_width_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o |-> (max_width_i[1] || cyc_size_o <= {1'b0, max_width_i[0]}));

  assert_lane_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o |-> $countones(cyc_lanes_o) == (1 << cyc_size_o));

  assert_enabled_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o |-> (cyc_lanes_o & beat_be_ni) == 4'b0000);

  assert_ascending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o && cyc_ack_i |=> !cyc_req_o || cyc_addr_o[1:0] > $past(cyc_addr_o[1:0]));

  assert_ready_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_ready_o |=> !beat_ready_o);

  assert_ready_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_ready_o |-> !cyc_req_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_req_o && !cyc_ack_i |=> cyc_req_o && $stable(cyc_addr_o) &&
                               $stable(cyc_size_o) && $stable(cyc_lanes_o));
endmodule

bind beat_splitter beat_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beat_ready_o (beat_ready_o),
  .beat_be_ni   (beat_be_ni),
  .max_width_i  (max_width_i),
  .cyc_req_o    (cyc_req_o),
  .cyc_ack_i    (cyc_ack_i),
  .cyc_addr_o   (cyc_addr_o),
  .cyc_size_o   (cyc_size_o),
  .cyc_lanes_o  (cyc_lanes_o)
);

// File: tb/tb_beat_splitter.sv
`timescale 1ns/1ps
module tb_beat_splitter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        beat_valid_i = 1'b0;
  logic        beat_ready_o;
  logic [29:0] beat_word_i = '0;
  logic [3:0]  beat_be_ni = 4'hF;
  logic [1:0]  max_width_i = 2'b00;
  logic        cyc_req_o;
  logic        cyc_ack_i = 1'b0;
  logic [31:0] cyc_addr_o;
  logic [1:0]  cyc_size_o;
  logic [3:0]  cyc_lanes_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  beat_splitter dut (
    .clk_i, .rst_ni, .beat_valid_i, .beat_ready_o, .beat_word_i, .beat_be_ni,
    .max_width_i, .cyc_req_o, .cyc_ack_i, .cyc_addr_o, .cyc_size_o, .cyc_lanes_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // eoff/esz: expected offset and size per cycle, lowest first
  task automatic run_beat(input logic [29:0] word, input logic [3:0] be_n,
                          input logic [1:0] w, input int n_exp,
                          input logic [3:0][1:0] eoff, input logic [3:0][1:0] esz,
                          input int gap, input string req);
    int got = 0, waits = 0, t = 0;
    bit done = 0;
    logic [31:0] held_addr = '0;
    @(negedge clk_i);
    beat_word_i = word; beat_be_ni = be_n; max_width_i = w; beat_valid_i = 1'b1;
    while (!done && t < 100) begin
      @(negedge clk_i);
      t++;
      cyc_ack_i = 1'b0;
      if (beat_ready_o) begin
        done = 1;
        check(got == n_exp, req, "ready after all cycles (R9)", 64'(got), 64'(n_exp));
        check(!cyc_req_o, req, "ready excludes request (R9)", 64'(cyc_req_o), 0);
      end else if (cyc_req_o) begin
        if (waits < gap) begin
          if (waits > 0)
            check(cyc_addr_o == held_addr, req, "held address (R10)", 64'(cyc_addr_o), 64'(held_addr));
          held_addr = cyc_addr_o;
          waits++;
        end else begin
          if (got < n_exp) begin
            check(cyc_addr_o == {word, eoff[got]}, req, "cycle address (R2 R6 R11)",
                  64'(cyc_addr_o), 64'({word, eoff[got]}));
            check(cyc_size_o == esz[got], req, "cycle size (R3 R7)",
                  64'(cyc_size_o), 64'(esz[got]));
            check(cyc_lanes_o == (4'((1 << (1 << esz[got])) - 1) << eoff[got]), req,
                  "cycle lanes (R4 R5)", 64'(cyc_lanes_o),
                  64'(4'((1 << (1 << esz[got])) - 1) << eoff[got]));
          end else begin
            check(0, req, "extra cycle (R5)", 64'(got + 1), 64'(n_exp));
          end
          got++;
          waits = 0;
          cyc_ack_i = 1'b1;
        end
      end
    end
    check(done, req, "beat completed", 64'(done), 1);
    if (n_exp == 0) check(t == 1, req, "empty beat latency (R8)", 64'(t), 1);
    @(negedge clk_i);
    beat_valid_i = 1'b0;
    check(!beat_ready_o, req, "ready one cycle (R9)", 64'(beat_ready_o), 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk_i);
    check(!beat_ready_o && !cyc_req_o, "R1", "outputs in reset",
          64'({beat_ready_o, cyc_req_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!beat_ready_o && !cyc_req_o, "R1", "idle after reset",
          64'({beat_ready_o, cyc_req_o}), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    test_reset();
    // full word at each width
    run_beat(30'h1234567, 4'b0000, 2'b10, 1, {2'd0,2'd0,2'd0,2'd0}, {2'd0,2'd0,2'd0,2'd2}, 0, "R3");
    run_beat(30'h0000abc, 4'b0000, 2'b11, 1, {2'd0,2'd0,2'd0,2'd0}, {2'd0,2'd0,2'd0,2'd2}, 0, "R3");
    run_beat(30'h3ffffff, 4'b0000, 2'b01, 2, {2'd0,2'd0,2'd2,2'd0}, {2'd0,2'd0,2'd1,2'd1}, 0, "R7");
    run_beat(30'h0000001, 4'b0000, 2'b00, 4, {2'd3,2'd2,2'd1,2'd0}, {2'd0,2'd0,2'd0,2'd0}, 0, "R3");
    // three contiguous bytes: always single bytes
    run_beat(30'h0000100, 4'b1000, 2'b01, 3, {2'd0,2'd2,2'd1,2'd0}, {2'd0,2'd0,2'd0,2'd0}, 0, "R7");
    run_beat(30'h0000100, 4'b1000, 2'b00, 3, {2'd0,2'd2,2'd1,2'd0}, {2'd0,2'd0,2'd0,2'd0}, 0, "R7");
    run_beat(30'h2aaaaaa, 4'b0001, 2'b10, 3, {2'd0,2'd3,2'd2,2'd1}, {2'd0,2'd0,2'd0,2'd0}, 0, "R6");
    // aligned halfwords
    run_beat(30'h0000055, 4'b1100, 2'b10, 1, {2'd0,2'd0,2'd0,2'd0}, {2'd0,2'd0,2'd0,2'd1}, 0, "R7");
    run_beat(30'h0000055, 4'b0011, 2'b01, 1, {2'd0,2'd0,2'd0,2'd2}, {2'd0,2'd0,2'd0,2'd1}, 0, "R2");
    run_beat(30'h0000055, 4'b0011, 2'b00, 2, {2'd0,2'd0,2'd3,2'd2}, {2'd0,2'd0,2'd0,2'd0}, 0, "R3");
    // straddling and sparse patterns
    run_beat(30'h0000077, 4'b1001, 2'b10, 2, {2'd0,2'd0,2'd2,2'd1}, {2'd0,2'd0,2'd0,2'd0}, 0, "R7");
    run_beat(30'h0000077, 4'b1010, 2'b10, 2, {2'd0,2'd0,2'd2,2'd0}, {2'd0,2'd0,2'd0,2'd0}, 0, "R5");
    run_beat(30'h0000077, 4'b0110, 2'b10, 2, {2'd0,2'd0,2'd3,2'd0}, {2'd0,2'd0,2'd0,2'd0}, 0, "R6");
    run_beat(30'h0000077, 4'b1101, 2'b10, 1, {2'd0,2'd0,2'd0,2'd1}, {2'd0,2'd0,2'd0,2'd0}, 0, "R5");
    // nothing enabled
    run_beat(30'h0000009, 4'b1111, 2'b10, 0, {2'd0,2'd0,2'd0,2'd0}, {2'd0,2'd0,2'd0,2'd0}, 0, "R8");
    // stalled acknowledges
    run_beat(30'h1555555, 4'b0000, 2'b01, 2, {2'd0,2'd0,2'd2,2'd0}, {2'd0,2'd0,2'd1,2'd1}, 3, "R10");
    run_beat(30'h1555555, 4'b0100, 2'b00, 3, {2'd0,2'd3,2'd1,2'd0}, {2'd0,2'd0,2'd0,2'd0}, 2, "R10");
    // stray acknowledge while idle has no effect
    @(negedge clk_i); cyc_ack_i = 1'b1;
    @(negedge clk_i); cyc_ack_i = 1'b0;
    check(!cyc_req_o && !beat_ready_o, "R9", "idle ack ignored",
          64'({cyc_req_o, beat_ready_o}), 0);
    run_beat(30'h0000200, 4'b1110, 2'b10, 1, {2'd0,2'd0,2'd0,2'd0}, {2'd0,2'd0,2'd0,2'd0}, 0, "R11");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule